// File: doc/BRIEF.md
# Configurable Serial Port Transceiver

This block is a full-duplex asynchronous serial port. Words to be sent arrive on a valid/ready stream. A holding register takes one word, and the transmit shifter serialises another, so the host can queue the next word while the current one is on the line. Received words leave on a second valid/ready stream. The receive output register holds one finished word while the receiver is already assembling the next one. The payload length and the parity options are set on plain control pins. A status flag and a level interrupt report problems on the receive side.

Bit timing comes from a tick running at sixteen times the bit rate. The tick is made either by an internal chain or by an external clock pin. The internal chain is a prescaler with an irregular ratio, followed by a power-of-two divider. When the external clock pin is selected, each of its rising edges, after synchronisation, is one tick. The receiver looks for a start bit on these ticks and confirms it at the middle of the bit. It then samples every later bit at its middle. Overruns and framing errors are reported through one shared error flag. Parity mismatches have a flag of their own.

Stream rules:
- A transmit word is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the holding register is occupied.
- `rx_data` holds its value while `rx_valid` is high and `rx_ready` is low.
- A received word is consumed on a clock edge where `rx_valid` and `rx_ready` are both high.
- The receiver has no back-pressure towards the line. A word that ends while the previous one has not been consumed is an overrun.

Top module: `uart_core`

## Requirements
- R1: While reset is held low, the port is idle. `txd` is 1 and `tx_ready` is 1. `tx_irq`, `rx_valid`, `err`, `par_err` and `rx_irq` are 0.
- R2: A transmitted frame is made of three parts, in this order:
  - a start bit at 0;
  - the payload bits, least significant first;
  - a stop bit at 1.

  The payload length is set by `mode`: 00 gives 5 bits, 01 gives 8 bits, 10 and 11 give 9 bits. Bit 8 of `tx_data` and `rx_data` is used only when the payload is 9 bits.
- R3: When `par_en` is 1, the top payload bit is a parity bit, and the data length is the payload length minus one. With `par_odd` at 0, the number of ones across the data bits and the parity bit is even. With `par_odd` at 1, that number is odd.
- R4: With `ext_sel` at 0, one bit lasts 16 × P × 2^`rate_sel` clock cycles. P is set by `pre_sel`: 00 gives 4, 01 gives 6, 10 gives 13 and 11 gives 65.
- R5: With `ext_sel` at 1, one bit lasts 16 rising edges of `ext_clk`.
- R6: The holding register is moved into the shifter on a tick, when the shifter is idle or is finishing a stop bit. `tx_irq` is high for exactly one cycle at that move, and `tx_ready` is high again in the same cycle. While the holding register is occupied, `tx_ready` stays low.
- R7: A frame whose stop bit is sampled high is delivered on `rx_data` with its parity bit and unused upper bits cleared. `rx_valid` rises in the cycle in which the stop bit is sampled. `rx_valid` falls in the cycle after a handshake.
- R8: A low pulse on `rxd` shorter than half a bit is not taken as a start bit. It leaves `rx_valid` and `err` at 0. After such a pulse, a new start is accepted only once the line has been seen high.
- R9: `err` is set and stays set until `err_clr` is pulsed, in two cases:
  - A stop bit sampled low sets `err`, and no word is delivered.
  - A frame that completes while `rx_valid` is high, with no handshake in that same cycle, sets `err` and keeps the old word. If the handshake falls in that same cycle, the new word is delivered and no error is raised.
- R10: A parity mismatch sets `par_err`, and the word is still delivered. `err_clr` clears `err` and `par_err`. A new error in the same cycle as `err_clr` wins, and the flag stays set.
- R11: `rx_irq` is high whenever `rx_valid`, `err` or `par_err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Payload length select |
| par_en | input | 1 | Use the top payload bit as parity |
| par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| pre_sel | input | 2 | Prescaler ratio select |
| rate_sel | input | RSEL_W | Power-of-two divider exponent |
| ext_sel | input | 1 | Take ticks from `ext_clk` |
| ext_clk | input | 1 | External 16x clock |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register free |
| tx_data | input | 9 | Transmit word |
| txd | output | 1 | Serial output line |
| tx_irq | output | 1 | Pulse when the holding register moves into the shifter |
| rxd | input | 1 | Serial input line |
| rx_valid | output | 1 | Received word present |
| rx_ready | input | 1 | Host takes the received word |
| rx_data | output | 9 | Received word |
| err_clr | input | 1 | Clear `err` and `par_err` |
| err | output | 1 | Overrun or framing error |
| par_err | output | 1 | Parity mismatch |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Two receive events can fall in the same clock edge: the host consumes a word, and the stop bit of the next frame is sampled. The bench first sends one frame, starting on a known phase of the prescaler, and measures how many cycles pass from the start of that frame to the rise of `rx_valid`. It then sends a second frame on the same phase without reading the first word. It raises `rx_ready` for exactly the one edge at which the second stop bit is sampled. The result is judged by three checks: `rx_valid` stays high, `rx_data` carries the second word, and `err` stays 0. An overrun that is raised on this edge by mistake is reported as a failure.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int PAY_W = 9;
  localparam int FRM_W = PAY_W + 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

  // payload length in bits for a mode code
  function automatic logic [3:0] pay_len(input logic [1:0] m);
    case (m)
      2'b00:   return 4'd5;
      2'b01:   return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  // data length once an optional parity bit is taken out
  function automatic logic [3:0] data_len(input logic [1:0] m, input logic pe);
    return pay_len(m) - {3'b000, pe};
  endfunction

  // prescaler ratio for a select code
  function automatic logic [6:0] pre_div(input logic [1:0] s);
    case (s)
      2'b00:   return 7'd4;
      2'b01:   return 7'd6;
      2'b10:   return 7'd13;
      default: return 7'd65;
    endcase
  endfunction

  function automatic logic [PAY_W-1:0] low_mask(input logic [3:0] n);
    logic [PAY_W:0] t;
    t = ({{PAY_W{1'b0}}, 1'b1} << n) - 1'b1;
    return t[PAY_W-1:0];
  endfunction
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int RSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pre_sel,
  input  logic [RSEL_W-1:0] rate_sel,
  input  logic              ext_sel,
  input  logic              ext_clk,
  output logic              tick
);
  import uart_pkg::*;

  localparam int RCNT_W = (1 << RSEL_W) - 1;
  localparam int PCNT_W = 7;

  logic [PCNT_W-1:0] pre_cnt, pre_lim;
  logic [RCNT_W-1:0] rate_cnt, rate_lim;
  logic              pre_stb, int_tick, ext_tick;
  logic [2:0]        ext_q;

  assign pre_lim  = pre_div(pre_sel) - 7'd1;
  assign pre_stb  = (pre_cnt >= pre_lim);
  assign rate_lim = ~({RCNT_W{1'b1}} << rate_sel);
  assign int_tick = pre_stb && (rate_cnt >= rate_lim);
  assign ext_tick = ext_q[1] && !ext_q[2];
  assign tick     = ext_sel ? ext_tick : int_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
      ext_q    <= '0;
    end else begin
      ext_q   <= {ext_q[1:0], ext_clk};
      pre_cnt <= pre_stb ? '0 : pre_cnt + 1'b1;
      if (pre_stb) rate_cnt <= (rate_cnt >= rate_lim) ? '0 : rate_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] mode,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [8:0] in_data,
  output logic       txd,
  output logic       moved
);
  import uart_pkg::*;

  logic [PAY_W-1:0] hold_q, dmask, pay;
  logic             hold_full, busy, par_bit, bit_end, last, load;
  logic [FRM_W-1:0] sh, frame, fill;
  logic [3:0]       tcnt, bleft, n, dl;

  always_comb begin
    n       = pay_len(mode);
    dl      = data_len(mode, par_en);
    dmask   = hold_q & low_mask(dl);
    par_bit = (^dmask) ^ par_odd;
    pay     = dmask;
    if (par_en) pay[dl] = par_bit;
    fill    = {FRM_W{1'b1}} << (n + 4'd1);
    frame   = ({2'b00, pay} << 1) | fill;
  end

  assign bit_end  = busy && tick && (tcnt == 4'd15);
  assign last     = bit_end && (bleft == 4'd1);
  assign load     = tick && hold_full && (!busy || last);
  assign in_ready = !hold_full;
  assign txd      = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      sh        <= '1;
      tcnt      <= '0;
      bleft     <= '0;
      moved     <= 1'b0;
    end else begin
      moved <= load;
      if (load) begin
        sh        <= frame;
        busy      <= 1'b1;
        tcnt      <= '0;
        bleft     <= n + 4'd2;
        hold_full <= 1'b0;
      end else begin
        if (busy && tick) tcnt <= tcnt + 4'd1;
        if (bit_end) begin
          sh    <= {1'b1, sh[FRM_W-1:1]};
          bleft <= bleft - 4'd1;
          if (last) busy <= 1'b0;
        end
        if (in_valid && !hold_full) begin
          hold_q    <= in_data;
          hold_full <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] mode,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rxd,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [8:0] out_data,
  input  logic       err_clr,
  output logic       err,
  output logic       par_err
);
  import uart_pkg::*;

  rx_state_t        st;
  logic [1:0]       sync_q;
  logic             rx, armed;
  logic [3:0]       cnt, bidx, n, dl;
  logic [PAY_W-1:0] sh, got;
  logic             bad_par, stop_now, frame_ok, frame_bad, rd, ovr;

  assign rx = sync_q[1];
  assign n  = pay_len(mode);
  assign dl = data_len(mode, par_en);

  always_comb begin
    got       = sh & low_mask(dl);
    bad_par   = par_en && ((^(sh & low_mask(n))) != par_odd);
    stop_now  = (st == RX_BITS) && tick && (cnt == 4'd15) && (bidx == n);
    frame_ok  = stop_now && rx;
    frame_bad = stop_now && !rx;
    rd        = out_valid && out_ready;
    ovr       = frame_ok && out_valid && !rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st     <= RX_IDLE;
      armed  <= 1'b0;
      cnt    <= '0;
      bidx   <= '0;
      sh     <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      case (st)
        RX_IDLE: begin
          if (tick && rx) armed <= 1'b1;
          if (tick && !rx && armed) begin
            st    <= RX_START;
            cnt   <= '0;
            armed <= 1'b0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (rx) st <= RX_IDLE;
            else if (cnt == 4'd7) begin
              st   <= RX_BITS;
              cnt  <= '0;
              bidx <= '0;
              sh   <= '0;
            end else cnt <= cnt + 4'd1;
          end
        end
        default: begin
          if (tick) begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd15) begin
              if (bidx == n) st <= RX_IDLE;
              else begin
                sh[bidx] <= rx;
                bidx     <= bidx + 4'd1;
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      err       <= 1'b0;
      par_err   <= 1'b0;
    end else begin
      if (frame_ok && !ovr) begin
        out_data  <= got;
        out_valid <= 1'b1;
      end else if (rd) out_valid <= 1'b0;
      if (frame_bad || ovr) err <= 1'b1;
      else if (err_clr)     err <= 1'b0;
      if (frame_ok && !ovr && bad_par) par_err <= 1'b1;
      else if (err_clr)                par_err <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_core.sv
module uart_core #(
  parameter int RSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [1:0]        pre_sel,
  input  logic [RSEL_W-1:0] rate_sel,
  input  logic              ext_sel,
  input  logic              ext_clk,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [8:0]        tx_data,
  output logic              txd,
  output logic              tx_irq,
  input  logic              rxd,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [8:0]        rx_data,
  input  logic              err_clr,
  output logic              err,
  output logic              par_err,
  output logic              rx_irq
);
  logic tick;

  uart_baud #(.RSEL_W(RSEL_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .rate_sel(rate_sel),
    .ext_sel(ext_sel), .ext_clk(ext_clk), .tick(tick)
  );

  uart_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .par_en(par_en),
    .par_odd(par_odd), .in_valid(tx_valid), .in_ready(tx_ready),
    .in_data(tx_data), .txd(txd), .moved(tx_irq)
  );

  uart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .par_en(par_en),
    .par_odd(par_odd), .rxd(rxd), .out_valid(rx_valid), .out_ready(rx_ready),
    .out_data(rx_data), .err_clr(err_clr), .err(err), .par_err(par_err)
  );

  assign rx_irq = rx_valid || err || par_err;
endmodule

// File: rtl/uart_chk.sv
module uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       tx_ready,
  input logic       tx_irq,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [8:0] rx_data,
  input logic       err,
  input logic       err_clr,
  input logic       par_err
);
  AST_MOVE_FREES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_ready); // R6
  AST_MOVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R6
  AST_START_AT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> !txd); // R2
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err); // R9
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !err_clr) |=> par_err); // R10
endmodule

bind uart_core uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_ready(tx_ready), .tx_irq(tx_irq),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .err(err),
  .err_clr(err_clr), .par_err(par_err)
);

// File: tb/sim_uart_core.sv
`timescale 1ns/1ps
module sim_uart_core;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b01, pre_sel = 2'b00;
  logic       par_en = 1'b0, par_odd = 1'b0, ext_sel = 1'b0, ext_clk = 1'b0, ext_run = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic       tx_valid = 1'b0, rxd_drv = 1'b1, rx_ready = 1'b0, err_clr = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_ready, txd, tx_irq, rx_valid, err, par_err, rx_irq;
  logic [8:0] rx_data;

  int cyc = 0, ntot = 0, nbad = 0, irq_cnt = 0, rise_cyc = 0;
  logic prev_v = 1'b0;

  always #10 clk = ~clk;
  always begin
    #80;
    if (ext_run) ext_clk = ~ext_clk;
  end
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rx_valid && !prev_v) rise_cyc = cyc;
    prev_v = rx_valid;
    if (tx_irq) irq_cnt = irq_cnt + 1;
  end

  uart_core u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .par_en(par_en), .par_odd(par_odd),
    .pre_sel(pre_sel), .rate_sel(rate_sel), .ext_sel(ext_sel), .ext_clk(ext_clk),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .txd(txd),
    .tx_irq(tx_irq), .rxd(rxd_drv), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .err_clr(err_clr), .err(err), .par_err(par_err), .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int plen(input logic [1:0] m);
    return (m == 2'b00) ? 5 : (m == 2'b01) ? 8 : 9;
  endfunction

  function automatic logic [8:0] exp_data(input logic [8:0] d, input logic [1:0] m, input logic pe);
    int dl = plen(m) - int'(pe);
    logic [8:0] r = '0;
    for (int i = 0; i < dl; i++) r[i] = d[i];
    return r;
  endfunction

  function automatic logic [8:0] exp_pay(input logic [8:0] d, input logic [1:0] m,
                                         input logic pe, input logic po);
    logic [8:0] r = exp_data(d, m, pe);
    int ones = 0;
    for (int i = 0; i < 9; i++) ones += int'(r[i]);
    if (pe) r[plen(m) - 1] = logic'(ones % 2) ^ po;
    return r;
  endfunction

  task automatic send_tx(input logic [8:0] d);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic mon_tx(input int n, input int bt, output logic [8:0] pay,
                        output logic startv, output logic stopv);
    int w = 0;
    pay = '0;
    while (txd !== 1'b0 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    repeat (bt / 2) @(negedge clk);
    startv = txd;
    for (int i = 0; i < n; i++) begin
      repeat (bt) @(negedge clk);
      pay[i] = txd;
    end
    repeat (bt) @(negedge clk);
    stopv = txd;
  endtask

  task automatic drive_frame(input logic [8:0] pay, input int n, input logic stopv, input int bt);
    rxd_drv = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd_drv = pay[i];
      repeat (bt) @(negedge clk);
    end
    rxd_drv = stopv;
    repeat (bt) @(negedge clk);
    rxd_drv = 1'b1;
  endtask

  task automatic rx_take();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic meas_bit(input logic [1:0] ps, input logic [2:0] rs, input logic es,
                          input int exp, input string tag);
    int len = 0;
    pre_sel = ps; rate_sel = rs; ext_sel = es; mode = 2'b00; par_en = 1'b0;
    repeat (20) @(negedge clk);
    send_tx(9'h001);
    while (txd !== 1'b0) @(negedge clk);
    while (txd === 1'b0) begin
      @(negedge clk);
      len++;
    end
    chk(len == exp, tag, len, exp);
    repeat (7 * exp + 20) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++;
    ntot++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    logic [8:0] p1, p2, d, ep;
    logic s1, s2, st1, st2, pe, po;
    logic [1:0] m;
    int t0, t1, dlt, c0;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
    chk(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
    chk({tx_irq, rx_valid, err, par_err, rx_irq} == 5'b0, "R1 flags low",
        int'({tx_irq, rx_valid, err, par_err, rx_irq}), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R2 / R3 / R7: random frames out on txd, then driven back into rxd
    for (int k = 0; k < 12; k++) begin
      m  = 2'($urandom % 4);
      pe = 1'($urandom % 2);
      po = 1'($urandom % 2);
      d  = 9'($urandom % 512);
      if (k == 0) begin m = 2'b10; pe = 1'b0; d = 9'h1A5; end
      if (k == 1) begin m = 2'b01; pe = 1'b1; po = 1'b1; d = 9'h0FF; end
      mode = m; par_en = pe; par_odd = po;
      ep = exp_pay(d, m, pe, po);
      fork
        send_tx(d);
        mon_tx(plen(m), 64, p1, st1, s1);
      join
      chk(st1 == 1'b0, "R2 start bit", int'(st1), 0);
      chk(p1 == ep, pe ? "R3 tx payload with parity" : "R2 tx payload", int'(p1), int'(ep));
      chk(s1 == 1'b1, "R2 stop bit", int'(s1), 1);
      repeat (40) @(negedge clk);
      drive_frame(ep, plen(m), 1'b1, 64);
      chk(rx_valid == 1'b1, "R7 rx_valid after stop", int'(rx_valid), 1);
      chk(rx_data == exp_data(d, m, pe), "R7 rx_data", int'(rx_data), int'(exp_data(d, m, pe)));
      chk(par_err == 1'b0, "R3 parity accepted", int'(par_err), 0);
      chk(rx_irq == 1'b1, "R11 rx_irq with data", int'(rx_irq), 1);
      rx_take();
      chk(rx_valid == 1'b0, "R7 handshake clears", int'(rx_valid), 0);
      chk(rx_irq == 1'b0, "R11 rx_irq idle", int'(rx_irq), 0);
    end

    // R4 / R5: bit time
    meas_bit(2'b01, 3'd1, 1'b0, 192, "R4 pre6 rate1");
    meas_bit(2'b10, 3'd0, 1'b0, 208, "R4 pre13");
    meas_bit(2'b11, 3'd0, 1'b0, 1040, "R4 pre65");
    meas_bit(2'b00, 3'd2, 1'b0, 256, "R4 pre4 rate2");
    ext_run = 1'b1;
    meas_bit(2'b00, 3'd0, 1'b1, 128, "R5 external clock");
    ext_run = 1'b0;
    ext_sel = 1'b0; pre_sel = 2'b00; rate_sel = 3'd0;
    mode = 2'b01; par_en = 1'b0;
    repeat (20) @(negedge clk);

    // R6: double buffering, back-to-back frames
    c0 = irq_cnt;
    fork
      begin
        mon_tx(8, 64, p1, st1, s1);
        mon_tx(8, 64, p2, st2, s2);
      end
      begin
        send_tx(9'h0C3);
        wait (irq_cnt == c0 + 1);
        @(negedge clk);
        send_tx(9'h03C);
        chk(tx_ready == 1'b0, "R6 holding occupied", int'(tx_ready), 0);
      end
    join
    repeat (40) @(negedge clk);
    chk(p1 == 9'h0C3, "R6 first word", int'(p1), 'hC3);
    chk(p2 == 9'h03C, "R6 second word", int'(p2), 'h3C);
    chk(irq_cnt == c0 + 2, "R6 tx_irq pulses", irq_cnt - c0, 2);
    chk(tx_ready == 1'b1, "R6 ready again", int'(tx_ready), 1);

    // R8: short glitch rejected
    rxd_drv = 1'b0;
    repeat (16) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (1500) @(negedge clk);
    chk(rx_valid == 1'b0, "R8 glitch no data", int'(rx_valid), 0);
    chk(err == 1'b0, "R8 glitch no error", int'(err), 0);
    drive_frame(9'h05A, 8, 1'b1, 64);
    chk(rx_data == 9'h05A && rx_valid, "R8 recovers", int'(rx_data), 'h5A);
    rx_take();

    // R9: framing error
    repeat (50) @(negedge clk);
    drive_frame(9'h0F3, 8, 1'b0, 64);
    chk(err == 1'b1, "R9 framing sets err", int'(err), 1);
    chk(rx_valid == 1'b0, "R9 framing no data", int'(rx_valid), 0);
    chk(rx_irq == 1'b1, "R11 rx_irq on error", int'(rx_irq), 1);
    repeat (100) @(negedge clk);
    pulse_clr();
    chk(err == 1'b0, "R10 clear err", int'(err), 0);

    // R9: overrun keeps old word
    repeat (50) @(negedge clk);
    drive_frame(9'h011, 8, 1'b1, 64);
    repeat (50) @(negedge clk);
    drive_frame(9'h022, 8, 1'b1, 64);
    chk(err == 1'b1, "R9 overrun sets err", int'(err), 1);
    chk(rx_data == 9'h011 && rx_valid, "R9 overrun keeps old", int'(rx_data), 'h11);
    rx_take();
    pulse_clr();

    // R9: read and completion in the same edge
    repeat (50) @(negedge clk);
    while (cyc % 4 != 0) @(negedge clk);
    t0 = cyc;
    drive_frame(9'h0A1, 8, 1'b1, 64);
    dlt = rise_cyc - t0;
    repeat (50) @(negedge clk);
    while (cyc % 4 != 0) @(negedge clk);
    t1 = cyc;
    fork
      drive_frame(9'h0B2, 8, 1'b1, 64);
      begin
        while (cyc != t1 + dlt - 1) @(negedge clk);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
      end
    join
    chk(rx_valid == 1'b1, "R9 coincident valid", int'(rx_valid), 1);
    chk(rx_data == 9'h0B2, "R9 coincident new word", int'(rx_data), 'hB2);
    chk(err == 1'b0, "R9 coincident no overrun", int'(err), 0);
    rx_take();

    // R10: parity mismatch, even parity, 7 data bits
    par_en = 1'b1; par_odd = 1'b0;
    repeat (50) @(negedge clk);
    drive_frame(9'h0D5, 8, 1'b1, 64);
    chk(par_err == 1'b1, "R10 parity mismatch", int'(par_err), 1);
    chk(rx_data == 9'h055 && rx_valid, "R10 word delivered", int'(rx_data), 'h55);
    rx_take();
    chk(rx_irq == 1'b1, "R11 rx_irq on par_err", int'(rx_irq), 1);
    pulse_clr();
    chk(par_err == 1'b0, "R10 clear par_err", int'(par_err), 0);

    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule